// File: doc/BRIEF.md
# Dual Integer Unit Issue Steering

This block takes up to two decoded integer instructions per cycle, older one first, and decides which of two integer execution units each one starts on. Each unit has a single execute stage. The block tracks how many cycles of work remain in that stage and reports when the unit cannot take a new operation. It raises a result-valid pulse carrying the instruction tag in the last cycle an operation spends in the stage. No arithmetic is performed. An operation is represented only by its tag and the number of cycles it holds the stage.

The two units do not accept the same operations. Unit 0 accepts every operation class. Unit 1 accepts only simple operations. The steering logic sends simple work to unit 1 whenever it can, so that unit 0 stays open for multiply and divide. Dispatch stays in program order: the younger candidate never starts unless the older one starts in the same cycle.

Top module: `int_issue_steer`

## Requirements
- R1: After a synchronous active-low reset, and after a reset applied while an operation is in flight, no unit reports busy and no result-valid pulse is raised.
- R2: A valid simple operation in the older slot goes to unit 1 when unit 1 can accept. Otherwise it goes to unit 0 when unit 0 can accept. Otherwise it waits.
- R3: Multiply and divide operations are only ever granted to unit 0. They wait while unit 0 cannot accept, even if unit 1 is idle.
- R4: A unit with more than one cycle of work left in its execute stage reports busy on u_busy and receives no grant.
- R5: A simple operation occupies its unit for one cycle. The unit raises res_valid with the tag in the cycle after the grant, and it may take a new operation in that same cycle.
- R6: A multiply or divide granted with latency field L (L of 0 counts as 1) raises res_valid with its tag exactly L cycles after the grant cycle. Busy is reported for cycles 1 to L-1 after the grant. The latency field is ignored for simple operations.
- R7: The younger candidate is taken only when the older candidate is taken in the same cycle. A younger candidate presented alone is not taken.
- R8: When both candidates issue in one cycle they use different units. Two simple operations with both units free put the older on unit 1 and the younger on unit 0.
- R9: Class encoding: 0 is simple, 1 is multiply, 2 is divide, and 3 is steered as simple.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| c0_valid | input | 1 | Older candidate present |
| c0_class | input | 2 | Older candidate operation class |
| c0_lat | input | LAT_W | Older candidate latency for multiply or divide |
| c0_tag | input | TAG_W | Older candidate tag |
| c1_valid | input | 1 | Younger candidate present |
| c1_class | input | 2 | Younger candidate operation class |
| c1_lat | input | LAT_W | Younger candidate latency for multiply or divide |
| c1_tag | input | TAG_W | Younger candidate tag |
| c_taken | output | 2 | Per-candidate accepted this cycle (bit 0 older) |
| c0_unit | output | 1 | Unit index the older candidate was steered to |
| c1_unit | output | 1 | Unit index the younger candidate was steered to |
| u_grant | output | 2 | Per-unit new operation starts this cycle |
| u_busy | output | 2 | Per-unit cannot accept this cycle |
| res_valid | output | 2 | Per-unit final cycle of execution |
| res_tag0 | output | TAG_W | Tag finishing on unit 0 |
| res_tag1 | output | TAG_W | Tag finishing on unit 1 |

## Verification
The bench sends a multiply to unit 0 and then presents a divide while that multiply still holds the stage. A design that checked only unit 1, or treated a multi-cycle unit as free, would start the divide too early. Back-to-back simple operations on unit 1 catch a design that idles a unit for an extra cycle after a one-cycle result. A younger simple operation offered while the older one waits catches a design that lets instructions pass each other. A latency field of zero, a long latency of twenty, the reserved class, and a reset in the middle of a long operation cover the edges of the countdown and of the class decode.

// File: rtl/int_issue_pkg.sv
// Shared definitions for the integer issue steering block.
// Assumes two candidate slots and two units; the class encoding is fixed.
package int_issue_pkg;
    typedef enum logic [1:0] {
        OPC_ALU = 2'd0,
        OPC_MUL = 2'd1,
        OPC_DIV = 2'd2,
        OPC_RSV = 2'd3
    } opc_e;

    localparam int NUM_SLOTS = 2;
    localparam int NUM_UNITS = 2;

    // True for classes that only the full-capability unit may execute.
    function automatic logic is_long_op(input logic [1:0] cls);
        return (cls == OPC_MUL) || (cls == OPC_DIV);
    endfunction
endpackage

// File: rtl/iu_exec_slot.sv
// One integer execute stage, modelled as an occupancy countdown.
// A grant loads the latency (0 is promoted to 1) and captures the tag.
// The stage can take new work when one cycle or less remains, so a
// single-cycle operation streams back to back.
module iu_exec_slot #(
    parameter int TAG_W = 6,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic [LAT_W-1:0] lat_in,
    input  logic [TAG_W-1:0] tag_in,
    output logic             can_accept,
    output logic             busy,
    output logic             res_valid,
    output logic [TAG_W-1:0] res_tag
);
    localparam logic [LAT_W-1:0] ONE  = LAT_W'(1);
    localparam logic [LAT_W-1:0] ZERO = '0;

    logic [LAT_W-1:0] remain_q;
    logic [TAG_W-1:0] tag_q;

    // Countdown of cycles the current operation still holds the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= ZERO;
        end else if (grant) begin
            remain_q <= (lat_in == ZERO) ? ONE : lat_in;
        end else if (remain_q != ZERO) begin
            remain_q <= remain_q - ONE;
        end
    end

    // Holds the tag of the operation occupying the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (grant) begin
            tag_q <= tag_in;
        end
    end

    // Status decode of the countdown.
    always_comb begin
        can_accept = (remain_q <= ONE);
        busy       = (remain_q > ONE);
        res_valid  = (remain_q == ONE);
        res_tag    = tag_q;
    end
endmodule

// File: rtl/iu_steer.sv
// Combinational steering of two in-order candidates onto two units.
// Unit 0 accepts any class; unit 1 accepts simple work only. Simple work
// prefers unit 1. A slot is considered only if every older slot issued.
module iu_steer
    import int_issue_pkg::*;
(
    input  logic [NUM_SLOTS-1:0] cand_valid,
    input  logic [NUM_SLOTS-1:0] cand_long,
    input  logic [NUM_UNITS-1:0] unit_free,
    output logic [NUM_SLOTS-1:0] take,
    output logic [NUM_SLOTS-1:0] route,
    output logic [NUM_UNITS-1:0] grant
);
    logic [NUM_UNITS-1:0] avail;
    logic                 chain_ok;

    // Walk the slots oldest first, consuming units as they are assigned.
    always_comb begin
        avail    = unit_free;
        chain_ok = 1'b1;
        take     = '0;
        route    = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (chain_ok && cand_valid[s]) begin
                if (!cand_long[s] && avail[1]) begin
                    take[s]  = 1'b1;
                    route[s] = 1'b1;
                    avail[1] = 1'b0;
                end else if (avail[0]) begin
                    take[s]  = 1'b1;
                    route[s] = 1'b0;
                    avail[0] = 1'b0;
                end
            end
            chain_ok = take[s];
        end
        grant = unit_free & ~avail;
    end
endmodule

// File: rtl/int_issue_steer.sv
// Top of the dual integer issue steering block.
// Decodes candidate classes, steers them, and drives one execute-stage
// tracker per unit. Simple operations always run for one cycle.
module int_issue_steer
    import int_issue_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             c0_valid,
    input  logic [1:0]       c0_class,
    input  logic [LAT_W-1:0] c0_lat,
    input  logic [TAG_W-1:0] c0_tag,
    input  logic             c1_valid,
    input  logic [1:0]       c1_class,
    input  logic [LAT_W-1:0] c1_lat,
    input  logic [TAG_W-1:0] c1_tag,
    output logic [1:0]       c_taken,
    output logic             c0_unit,
    output logic             c1_unit,
    output logic [1:0]       u_grant,
    output logic [1:0]       u_busy,
    output logic [1:0]       res_valid,
    output logic [TAG_W-1:0] res_tag0,
    output logic [TAG_W-1:0] res_tag1
);
    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    logic [NUM_SLOTS-1:0] slot_valid;
    logic [NUM_SLOTS-1:0] slot_long;
    logic [LAT_W-1:0]     slot_lat [NUM_SLOTS];
    logic [TAG_W-1:0]     slot_tag [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] take;
    logic [NUM_SLOTS-1:0] route;
    logic [NUM_UNITS-1:0] unit_free;
    logic [NUM_UNITS-1:0] grant;
    logic [LAT_W-1:0]     unit_lat [NUM_UNITS];
    logic [TAG_W-1:0]     unit_tag [NUM_UNITS];
    logic [TAG_W-1:0]     done_tag [NUM_UNITS];

    // Gather slot fields and fix simple operations to one cycle.
    always_comb begin
        slot_valid  = {c1_valid, c0_valid};
        slot_long   = {is_long_op(c1_class), is_long_op(c0_class)};
        slot_lat[0] = slot_long[0] ? c0_lat : ONE;
        slot_lat[1] = slot_long[1] ? c1_lat : ONE;
        slot_tag[0] = c0_tag;
        slot_tag[1] = c1_tag;
    end

    iu_steer u_steer (
        .cand_valid (slot_valid),
        .cand_long  (slot_long),
        .unit_free  (unit_free),
        .take       (take),
        .route      (route),
        .grant      (grant)
    );

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            // Pick the slot feeding this unit; the older slot wins a tie.
            always_comb begin
                if (take[0] && (route[0] == u[0])) begin
                    unit_lat[u] = slot_lat[0];
                    unit_tag[u] = slot_tag[0];
                end else begin
                    unit_lat[u] = slot_lat[1];
                    unit_tag[u] = slot_tag[1];
                end
            end

            iu_exec_slot #(
                .TAG_W (TAG_W),
                .LAT_W (LAT_W)
            ) u_exec (
                .clk        (clk),
                .rst_n      (rst_n),
                .grant      (grant[u]),
                .lat_in     (unit_lat[u]),
                .tag_in     (unit_tag[u]),
                .can_accept (unit_free[u]),
                .busy       (u_busy[u]),
                .res_valid  (res_valid[u]),
                .res_tag    (done_tag[u])
            );
        end
    endgenerate

    // Drive the steering results onto the ports.
    always_comb begin
        c_taken  = take;
        c0_unit  = route[0];
        c1_unit  = route[1];
        u_grant  = grant;
        res_tag0 = done_tag[0];
        res_tag1 = done_tag[1];
    end
endmodule

// File: rtl/int_issue_steer_chk.sv
// Property checker for int_issue_steer, bound to every instance.
// Observes ports only; assumes the synchronous active-low reset.
module int_issue_steer_chk #(
    parameter int TAG_W = 6,
    parameter int LAT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       c0_class,
    input logic [LAT_W-1:0] c0_lat,
    input logic [TAG_W-1:0] c0_tag,
    input logic [1:0]       c1_class,
    input logic [TAG_W-1:0] c1_tag,
    input logic [1:0]       c_taken,
    input logic             c0_unit,
    input logic             c1_unit,
    input logic [1:0]       u_grant,
    input logic [1:0]       u_busy,
    input logic             res_valid1,
    input logic [TAG_W-1:0] res_tag1
);
    // R3
    older_long_unit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_taken[0] && (c0_class == 2'd1 || c0_class == 2'd2)) |-> !c0_unit);

    // R3
    younger_long_unit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_taken[1] && (c1_class == 2'd1 || c1_class == 2'd2)) |-> !c1_unit);

    // R4
    busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (u_busy & u_grant) == 2'b00);

    // R7
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_taken[1] |-> c_taken[0]);

    // R8
    distinct_units_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_taken == 2'b11) |-> (c0_unit != c1_unit));

    // R5
    simple_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && u_grant[1]) |=> (res_valid1 &&
            res_tag1 == $past((c_taken[0] && c0_unit) ? c0_tag : c1_tag)));

    // R6
    long_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && c_taken[0] && !c0_unit && (c0_class == 2'd1 || c0_class == 2'd2)
            && c0_lat >= LAT_W'(2)) |=> u_busy[0]);
endmodule

bind int_issue_steer int_issue_steer_chk #(
    .TAG_W (TAG_W),
    .LAT_W (LAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .c0_class   (c0_class),
    .c0_lat     (c0_lat),
    .c0_tag     (c0_tag),
    .c1_class   (c1_class),
    .c1_tag     (c1_tag),
    .c_taken    (c_taken),
    .c0_unit    (c0_unit),
    .c1_unit    (c1_unit),
    .u_grant    (u_grant),
    .u_busy     (u_busy),
    .res_valid1 (res_valid[1]),
    .res_tag1   (res_tag1)
);

// File: tb/int_issue_steer_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a cycle-by-cycle vector table from reset, then
// directed tests for long latency, a blocked divide and mid-flight reset.
module int_issue_steer_tb;
    localparam int TAG_W = 6;
    localparam int LAT_W = 5;

    typedef struct packed {
        logic       v0;
        logic [1:0] c0;
        logic [4:0] l0;
        logic [5:0] t0;
        logic       v1;
        logic [1:0] c1;
        logic [4:0] l1;
        logic [5:0] t1;
        logic [1:0] take;
        logic       r0;
        logic       r1;
        logic [1:0] busy;
        logic [1:0] res;
        logic [5:0] rt0;
        logic [5:0] rt1;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // 0: idle after reset (R1)
        '{1'b0,2'd0,5'd0,6'd0, 1'b0,2'd0,5'd0,6'd0, 2'b00,1'b0,1'b0, 2'b00,2'b00,6'd0,6'd0},
        // 1: two simple, older to unit 1, younger to unit 0 (R2, R8)
        '{1'b1,2'd0,5'd1,6'd1, 1'b1,2'd0,5'd1,6'd2, 2'b11,1'b1,1'b0, 2'b00,2'b00,6'd0,6'd0},
        // 2: multiply lat 3 to unit 0, simple to unit 1 (R3, R5)
        '{1'b1,2'd1,5'd3,6'd3, 1'b1,2'd0,5'd1,6'd4, 2'b11,1'b0,1'b1, 2'b00,2'b11,6'd2,6'd1},
        // 3: unit 0 busy; back-to-back simple on unit 1, younger waits (R4, R5)
        '{1'b1,2'd0,5'd1,6'd5, 1'b1,2'd0,5'd1,6'd6, 2'b01,1'b1,1'b0, 2'b01,2'b10,6'd0,6'd4},
        // 4: divide blocked by busy unit 0 while unit 1 idle; younger held (R3, R4, R7)
        '{1'b1,2'd2,5'd2,6'd7, 1'b1,2'd0,5'd1,6'd8, 2'b00,1'b0,1'b0, 2'b01,2'b10,6'd0,6'd5},
        // 5: multiply result after 3 cycles; divide issues (R6)
        '{1'b1,2'd2,5'd2,6'd7, 1'b1,2'd0,5'd1,6'd8, 2'b11,1'b0,1'b1, 2'b00,2'b01,6'd3,6'd0},
        // 6: younger alone is not taken (R7)
        '{1'b0,2'd0,5'd0,6'd0, 1'b1,2'd0,5'd1,6'd9, 2'b00,1'b0,1'b0, 2'b01,2'b10,6'd0,6'd8},
        // 7: multiply lat 0 counts as 1; second multiply waits (R6, R3)
        '{1'b1,2'd1,5'd0,6'd10, 1'b1,2'd1,5'd4,6'd11, 2'b01,1'b0,1'b0, 2'b00,2'b01,6'd7,6'd0},
        // 8: simple with lat field 9 still one cycle (R6)
        '{1'b1,2'd0,5'd9,6'd12, 1'b0,2'd0,5'd0,6'd0, 2'b01,1'b1,1'b0, 2'b00,2'b01,6'd10,6'd0},
        // 9: reserved class steers as simple (R9)
        '{1'b1,2'd3,5'd7,6'd13, 1'b1,2'd3,5'd7,6'd14, 2'b11,1'b1,1'b0, 2'b00,2'b10,6'd0,6'd12},
        // 10: both results together (R5, R9)
        '{1'b0,2'd0,5'd0,6'd0, 1'b0,2'd0,5'd0,6'd0, 2'b00,1'b0,1'b0, 2'b00,2'b11,6'd14,6'd13}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             c0_valid = 1'b0;
    logic [1:0]       c0_class = '0;
    logic [LAT_W-1:0] c0_lat = '0;
    logic [TAG_W-1:0] c0_tag = '0;
    logic             c1_valid = 1'b0;
    logic [1:0]       c1_class = '0;
    logic [LAT_W-1:0] c1_lat = '0;
    logic [TAG_W-1:0] c1_tag = '0;
    logic [1:0]       c_taken;
    logic             c0_unit;
    logic             c1_unit;
    logic [1:0]       u_grant;
    logic [1:0]       u_busy;
    logic [1:0]       res_valid;
    logic [TAG_W-1:0] res_tag0;
    logic [TAG_W-1:0] res_tag1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    int_issue_steer #(.TAG_W(TAG_W), .LAT_W(LAT_W)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .c0_valid (c0_valid), .c0_class (c0_class), .c0_lat (c0_lat), .c0_tag (c0_tag),
        .c1_valid (c1_valid), .c1_class (c1_class), .c1_lat (c1_lat), .c1_tag (c1_tag),
        .c_taken (c_taken), .c0_unit (c0_unit), .c1_unit (c1_unit),
        .u_grant (u_grant), .u_busy (u_busy), .res_valid (res_valid),
        .res_tag0 (res_tag0), .res_tag1 (res_tag1)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply inputs just after the falling edge.
    task automatic drive(input logic v0, input logic [1:0] k0, input logic [4:0] l0,
                         input logic [5:0] t0, input logic v1, input logic [1:0] k1,
                         input logic [4:0] l1, input logic [5:0] t1);
        @(negedge clk);
        c0_valid = v0; c0_class = k0; c0_lat = l0; c0_tag = t0;
        c1_valid = v1; c1_class = k1; c1_lat = l1; c1_tag = t1;
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table walk, one vector per cycle.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].v0, VECS[i].c0, VECS[i].l0, VECS[i].t0,
                  VECS[i].v1, VECS[i].c1, VECS[i].l1, VECS[i].t1);
            check("R2/R7", $sformatf("vec%0d taken", i), 32'(c_taken), 32'(VECS[i].take));
            if (VECS[i].take[0])
                check("R2/R3", $sformatf("vec%0d older unit", i), 32'(c0_unit), 32'(VECS[i].r0));
            if (VECS[i].take[1])
                check("R8", $sformatf("vec%0d younger unit", i), 32'(c1_unit), 32'(VECS[i].r1));
            check("R4", $sformatf("vec%0d busy", i), 32'(u_busy), 32'(VECS[i].busy));
            check("R5/R6", $sformatf("vec%0d res_valid", i), 32'(res_valid), 32'(VECS[i].res));
            if (VECS[i].res[0])
                check("R5/R6", $sformatf("vec%0d tag0", i), 32'(res_tag0), 32'(VECS[i].rt0));
            if (VECS[i].res[1])
                check("R5/R6", $sformatf("vec%0d tag1", i), 32'(res_tag1), 32'(VECS[i].rt1));
        end

        // R6: multiply with latency 20 on unit 0.
        drive(1'b1, 2'd1, 5'd20, 6'd33, 1'b0, 2'd0, 5'd0, 6'd0);
        check("R6", "long mul taken", 32'(c_taken), 32'h1);
        check("R3", "long mul unit", 32'(c0_unit), 32'h0);
        for (int i = 1; i <= 20; i++) begin
            if (i == 5) begin
                // R4: divide offered while unit 0 is busy must wait.
                drive(1'b1, 2'd2, 5'd3, 6'd34, 1'b0, 2'd0, 5'd0, 6'd0);
                check("R4", "div while busy taken", 32'(c_taken), 32'h0);
            end else begin
                drive(1'b0, 2'd0, 5'd0, 6'd0, 1'b0, 2'd0, 5'd0, 6'd0);
            end
            if (i < 20) begin
                check("R6", $sformatf("long busy cyc%0d", i), 32'(u_busy[0]), 32'h1);
                check("R6", $sformatf("long no res cyc%0d", i), 32'(res_valid[0]), 32'h0);
            end else begin
                check("R6", "long res at 20", 32'(res_valid[0]), 32'h1);
                check("R6", "long res tag", 32'(res_tag0), 32'd33);
                check("R6", "long busy clear", 32'(u_busy[0]), 32'h0);
            end
        end

        // R1: reset while a multiply is in flight.
        drive(1'b1, 2'd1, 5'd10, 6'd40, 1'b0, 2'd0, 5'd0, 6'd0);
        drive(1'b0, 2'd0, 5'd0, 6'd0, 1'b0, 2'd0, 5'd0, 6'd0);
        check("R6", "busy before reset", 32'(u_busy[0]), 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1", "busy after reset", 32'(u_busy), 32'h0);
        check("R1", "res after reset", 32'(res_valid), 32'h0);
        repeat (10) begin
            drive(1'b0, 2'd0, 5'd0, 6'd0, 1'b0, 2'd0, 5'd0, 6'd0);
            check("R1", "no stale result", 32'(res_valid), 32'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule